// File: doc/BRIEF.md
# Fine-Trimmed Time-of-Day Counter

This block keeps a seconds-and-nanoseconds time of day for precision time protocols. On every cycle of its timing clock, a 32-bit phase accumulator adds a programmable addend. The nanosecond field advances by a programmable step only in the cycles where that addition carries out of the accumulator. The addend therefore trims the rate at which time advances, with a resolution of one part in 2^32. When the nanosecond field reaches one billion, it wraps and the seconds field counts up by one.

Software programs four values through a single write port: the addend, the step, and a start time made of seconds and nanoseconds. An initialise strobe copies the start time into the running counter. A capture strobe freezes a consistent copy of both fields so that they can be read without tearing. After reset the step is twice the clock period and the addend is at mid-range. The accumulator then carries on every second cycle, so a nominal clock gives real time with no further programming.

Top module: `ptp_fine_clock`

## Requirements
- R1: While reset is held, both time fields and both snapshot fields read zero. On release the addend is 0x8000_0000 and the step is twice the CLK_NS parameter (16 ns by default).
- R2: Each clock cycle the accumulator adds the addend. The nanosecond field moves by exactly the step in a cycle whose addition carries out of bit 31, and holds in every other cycle. With the reset addend and a cleared accumulator, the first carry falls on the second edge and every second edge after that.
- R3: A write to the addend is used starting from the cycle after the write edge. The write edge itself still adds the old addend, and the accumulator contents are kept.
- R4: When adding the step gives a value of 1,000,000,000 or more, the nanosecond field takes that value minus 1,000,000,000 and the seconds field increments in the same cycle. In every other cycle without an initialise strobe, the seconds field is unchanged.
- R5: An initialise strobe sampled on an edge loads the programmed start seconds and nanoseconds and clears the accumulator. It takes priority over a carry on that same edge.
- R6: A capture strobe sampled on an edge stores the seconds and nanoseconds values visible before that edge as one pair. The stored pair holds until the next capture strobe.
- R7: A new step value applies to every carry after its write edge.
- R8: The write selector codes are: 0 for the addend, 1 for the step (low 8 data bits), 2 for the start seconds, and 3 for the start nanoseconds (low 30 data bits). A write to the step or to a start value does not change the running time.
- R9: An addend of zero stops time. An addend of 0xFFFF_FFFF produces a carry on almost every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write enable |
| cfg_wr_sel | input | 2 | Configuration target select |
| cfg_wr_data | input | 32 | Configuration write data |
| init_load | input | 1 | Load start time and clear accumulator |
| capture | input | 1 | Latch a snapshot of the time |
| tod_sec | output | 32 | Running seconds |
| tod_ns | output | 30 | Running nanoseconds |
| snap_sec | output | 32 | Captured seconds |
| snap_ns | output | 30 | Captured nanoseconds |

## Verification
The accumulator cannot be seen at the ports, so a wrong phase shows up only as a carry that comes one edge early or late. The bench therefore checks the nanosecond field on every edge after each initialise, where the accumulator is known to be zero. A corrupted addend or step appears at the next carry, at most two edges later at the reset rate, as a wrong nanosecond delta. A wrong rollover or priority decision appears on the very edge it occurs, in both fields together. Because of this, the bench places one check directly on the rollover edge and one on an initialise edge that also carries.

// File: rtl/ptp_fine_pkg.sv
package ptp_fine_pkg;
    localparam int ACC_W  = 32;
    localparam int SEC_W  = 32;
    localparam int NS_W   = 30;
    localparam int INC_W  = 8;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 2;

    localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDEND = 2'd0,
        SEL_STEP   = 2'd1,
        SEL_SEC    = 2'd2,
        SEL_NS     = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;
endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
    import ptp_fine_pkg::*;
#(
    parameter int CLK_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [ACC_W-1:0]  addend_o,
    output logic [INC_W-1:0]  step_o,
    output tod_t              start_o
);
    localparam logic [INC_W-1:0] STEP_RST   = INC_W'(2 * CLK_NS);
    localparam logic [ACC_W-1:0] ADDEND_RST = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] addend;
        logic [INC_W-1:0] step;
        tod_t             start;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_hi;

    assign unused_hi = ^wr_data_i[DATA_W-1:NS_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (cfg_sel_e'(wr_sel_i))
                SEL_ADDEND: cfg_d.addend    = wr_data_i[ACC_W-1:0];
                SEL_STEP:   cfg_d.step      = wr_data_i[INC_W-1:0];
                SEL_SEC:    cfg_d.start.sec = wr_data_i[SEC_W-1:0];
                SEL_NS:     cfg_d.start.ns  = wr_data_i[NS_W-1:0];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.addend <= ADDEND_RST;
            cfg_q.step   <= STEP_RST;
            cfg_q.start  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign addend_o = cfg_q.addend;
    assign step_o   = cfg_q.step;
    assign start_o  = cfg_q.start;

    // R3: an addend write lands on the following cycle
    assert_addend_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_ADDEND) |=> addend_o == $past(wr_data_i[ACC_W-1:0]));
endmodule

// File: rtl/ptp_addend_acc.sv
module ptp_addend_acc
    import ptp_fine_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [ACC_W-1:0] addend_i,
    output logic             carry_o
);
    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q.phase} + {1'b0, addend_i};
        acc_d = acc_q;
        if (clear_i) acc_d.phase = '0;
        else         acc_d.phase = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign carry_o = sum[ACC_W];

    // R5: the initialise strobe empties the phase accumulator
    assert_acc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> acc_q.phase == '0);
    // R9: a zero addend never produces a carry
    assert_zero_addend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addend_i == '0) |-> !carry_o);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_fine_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry_i,
    input  logic [INC_W-1:0] step_i,
    input  logic             init_i,
    input  tod_t             start_i,
    output tod_t             tod_o
);
    tod_t tod_d, tod_q;
    logic [NS_W:0] ns_sum;

    always_comb begin
        tod_d  = tod_q;
        ns_sum = {1'b0, tod_q.ns} + (NS_W+1)'(step_i);
        if (init_i) begin
            tod_d = start_i;
        end else if (carry_i) begin
            if (ns_sum >= {1'b0, NS_PER_SEC}) begin
                tod_d.ns  = NS_W'(ns_sum - {1'b0, NS_PER_SEC});
                tod_d.sec = tod_q.sec + 1'b1;
            end else begin
                tod_d.ns  = ns_sum[NS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tod_q <= '0;
        else        tod_q <= tod_d;
    end

    assign tod_o = tod_q;

    // R2: no carry and no initialise means time stands still
    assert_hold_without_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !carry_i) |=> $stable(tod_q));
    // R4: seconds only step by one outside of an initialise
    assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (tod_q.sec == $past(tod_q.sec) || tod_q.sec == $past(tod_q.sec) + 1'b1));
    // R4: an in-range nanosecond value stays in range
    assert_ns_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && tod_q.ns < NS_PER_SEC) |=> tod_q.ns < NS_PER_SEC);
    // R5: the start time wins over a simultaneous carry
    assert_init_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> tod_q == $past(start_i));
endmodule

// File: rtl/ptp_snapshot.sv
module ptp_snapshot
    import ptp_fine_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture_i,
    input  tod_t tod_i,
    output tod_t snap_o
);
    tod_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (capture_i) snap_d = tod_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign snap_o = snap_q;

    // R6: the stored pair matches the time seen before the strobe edge
    assert_snap_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> snap_q == $past(tod_i));
    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(snap_q));
endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock
    import ptp_fine_pkg::*;
#(
    parameter int CLK_NS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_wr_sel,
    input  logic [31:0] cfg_wr_data,
    input  logic        init_load,
    input  logic        capture,
    output logic [31:0] tod_sec,
    output logic [29:0] tod_ns,
    output logic [31:0] snap_sec,
    output logic [29:0] snap_ns
);
    logic [ACC_W-1:0] addend;
    logic [INC_W-1:0] step;
    tod_t             start_tod;
    tod_t             run_tod;
    tod_t             snap_tod;
    logic             carry;

    ptp_cfg_regs #(.CLK_NS(CLK_NS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en),
        .wr_sel_i  (cfg_wr_sel),
        .wr_data_i (cfg_wr_data),
        .addend_o  (addend),
        .step_o    (step),
        .start_o   (start_tod)
    );

    ptp_addend_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (init_load),
        .addend_i (addend),
        .carry_o  (carry)
    );

    ptp_tod_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .carry_i (carry),
        .step_i  (step),
        .init_i  (init_load),
        .start_i (start_tod),
        .tod_o   (run_tod)
    );

    ptp_snapshot u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .tod_i     (run_tod),
        .snap_o    (snap_tod)
    );

    assign tod_sec  = run_tod.sec;
    assign tod_ns   = run_tod.ns;
    assign snap_sec = snap_tod.sec;
    assign snap_ns  = snap_tod.ns;
endmodule

// File: tb/ptp_fine_clock_bench.sv
module ptp_fine_clock_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        init_load = 1'b0;
    logic        capture = 1'b0;
    logic [31:0] tod_sec, snap_sec;
    logic [29:0] tod_ns, snap_ns;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_fine_clock u_ptp_fine_clock (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .init_load(init_load), .capture(capture),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .snap_sec(snap_sec), .snap_ns(snap_ns)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_tod(input string tag, input longint s, input longint ns);
        check({tag, " sec"}, tod_sec, s);
        check({tag, " ns"}, tod_ns, ns);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        step(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_init();
        init_load = 1'b1;
        step(1);
        init_load = 1'b0;
    endtask

    task automatic pulse_capture();
        capture = 1'b1;
        step(1);
        capture = 1'b0;
    endtask

    task automatic test_reset();
        step(3);
        check_tod("R1 reset", 0, 0);
        check("R1 reset snap sec", snap_sec, 0);
        check("R1 reset snap ns", snap_ns, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_nominal_rate();
        step(1);
        check_tod("R2 first edge no carry", 0, 0);
        step(1);
        check_tod("R1 R2 default step on second edge", 0, 16);
        step(8);
        check_tod("R2 mid-range addend every second edge", 0, 80);
    endtask

    task automatic test_addend_change();
        cfg_write(2'd0, 32'hFFFF_FFFF);
        check_tod("R3 write edge uses old addend", 0, 80);
        step(4);
        check_tod("R3 R9 full addend carries each edge", 0, 144);
        cfg_write(2'd0, 32'h0);
        check_tod("R3 last edge of old addend", 0, 160);
        step(6);
        check_tod("R9 zero addend stops time", 0, 160);
    endtask

    task automatic test_init_and_rollover();
        cfg_write(2'd2, 32'd5);
        cfg_write(2'd3, 32'd999_999_900);
        cfg_write(2'd1, 32'd40);
        cfg_write(2'd0, 32'h8000_0000);
        check_tod("R8 config writes leave time alone", 0, 160);
        pulse_init();
        check_tod("R5 start time loaded", 5, 999_999_900);
        step(1);
        check_tod("R5 cleared accumulator no carry", 5, 999_999_900);
        step(1);
        check_tod("R7 new step applied", 5, 999_999_940);
        step(2);
        check_tod("R7 second carry", 5, 999_999_980);
        step(2);
        check_tod("R4 rollover", 6, 20);
    endtask

    task automatic test_init_priority_and_capture();
        cfg_write(2'd0, 32'hFFFF_FFFF);
        check_tod("R3 addend write no step", 6, 20);
        pulse_init();
        check_tod("R5 init beats carry", 5, 999_999_900);
        step(1);
        check_tod("R5 accumulator zero after init", 5, 999_999_900);
        step(1);
        check_tod("R2 carry after init", 5, 999_999_940);
        pulse_capture();
        check("R6 snap sec", snap_sec, 5);
        check("R6 snap ns", snap_ns, 999_999_940);
        check_tod("R6 time moved past snapshot", 5, 999_999_980);
        step(2);
        check_tod("R4 rollover at full rate", 6, 60);
        check("R6 snap sec holds", snap_sec, 5);
        check("R6 snap ns holds", snap_ns, 999_999_940);
        pulse_capture();
        check("R6 second snap sec", snap_sec, 6);
        check("R6 second snap ns", snap_ns, 60);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_nominal_rate();
        test_addend_change();
        test_init_and_rollover();
        test_init_priority_and_capture();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule